// File: doc/BRIEF.md
# Half to Single Precision Widener

This block widens a 16-bit IEEE half-precision bit pattern into the 32-bit IEEE single-precision bit pattern of the same value. Every half value fits exactly in single precision, so the block never rounds. It handles every input class correctly: normal numbers, subnormals, signed zeros, infinities and NaNs.

A producer presents a half word together with a valid strobe. One clock later the widened word appears on the output, and the output valid strobe is raised in that same cycle. A half subnormal always becomes a normal single value. The block finds the leading one of the subnormal mantissa with a leading-zero count, shifts the mantissa left by that amount, and lowers the output exponent to match.

Top module: `half_to_single`

## Requirements
- R1: Input bit 15 (sign) appears unchanged at output bit 31 for every input class.
- R2: For an input biased exponent in 1..30, the output biased exponent (bits 30:23) equals the input exponent (bits 14:10) plus 112.
- R3: For normal, infinite and NaN inputs, the input mantissa (bits 9:0) appears at output bits 22:13. Output bits 12:0 are zero for every input.
- R4: An input exponent of 31 gives an output exponent of 255, and the mantissa is carried over by R3. Infinities stay infinite and NaN payloads are kept.
- R5: An input with exponent 0 and a nonzero mantissa becomes a normal output. With k leading zeros in the 10-bit mantissa, the output exponent is 112 - k, and output bits 22:13 hold the mantissa shifted left by k+1 with the leading one dropped.
- R6: Inputs 0x0000 and 0x8000 give 0x00000000 and 0x80000000.
- R7: Reset clears the output word and the output valid. The output valid equals the input valid of the previous cycle.
- R8: In a cycle with the input valid low, the output word keeps its value whatever the input word carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word strobe |
| inHalf | input | 16 | Half-precision bit pattern |
| outValid | output | 1 | Output word strobe, one cycle after inValid |
| outSingle | output | 32 | Single-precision bit pattern |

## Verification
The bench builds the block with its default field widths: a 5-bit and a 10-bit input field, and an 8-bit and a 23-bit output field. With these widths the input space has only 65536 patterns, so the bench sweeps all of them. Every subnormal shift count, both infinities and every NaN payload are therefore compared against a reference model that renormalizes by repeated doubling. Random words with interleaved idle cycles then check the one-cycle latency and the hold behaviour.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  typedef struct packed {
    logic load;
  } ctrlStrobeT;
endpackage

// File: rtl/h2s_ctrl.sv
module h2s_ctrl
  import h2s_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output ctrlStrobeT strobe,
  output logic       outValid
);
  always_comb strobe.load = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R7
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R7
endmodule

// File: rtl/h2s_datapath.sv
module h2s_datapath
  import h2s_pkg::*;
#(
  parameter int EXP_IN  = 5,
  parameter int MAN_IN  = 10,
  parameter int EXP_OUT = 8,
  parameter int MAN_OUT = 23,
  localparam int IN_W  = 1 + EXP_IN + MAN_IN,
  localparam int OUT_W = 1 + EXP_OUT + MAN_OUT
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [IN_W-1:0]  inWord,
  output logic [OUT_W-1:0] outWord
);
  localparam int BIAS_DIFF = (2 ** (EXP_OUT - 1)) - (2 ** (EXP_IN - 1));
  localparam int PAD_W = MAN_OUT - MAN_IN;
  localparam int LZ_W = $clog2(MAN_IN + 1);
  localparam logic [EXP_OUT-1:0] BIAS_ADJ = EXP_OUT'(BIAS_DIFF);

  logic               sgn;
  logic [EXP_IN-1:0]  expIn;
  logic [MAN_IN-1:0]  manIn;
  logic [LZ_W-1:0]    lzCnt;
  logic [MAN_IN-1:0]  normMan;
  logic [EXP_OUT-1:0] expNext;
  logic [MAN_IN-1:0]  manNext;
  logic [OUT_W-1:0]   wordNext;

  assign sgn   = inWord[IN_W-1];
  assign expIn = inWord[IN_W-2 -: EXP_IN];
  assign manIn = inWord[MAN_IN-1:0];

  // leading-zero count: highest set bit wins
  always_comb begin
    lzCnt = LZ_W'(MAN_IN);
    for (int i = 0; i < MAN_IN; i++) begin
      if (manIn[i]) lzCnt = LZ_W'(MAN_IN - 1 - i);
    end
  end

  assign normMan = manIn << (lzCnt + 1'b1);

  always_comb begin
    if (expIn == '1) begin
      expNext = '1;
      manNext = manIn;
    end else if (expIn == '0) begin
      if (manIn == '0) begin
        expNext = '0;
        manNext = '0;
      end else begin
        expNext = BIAS_ADJ - EXP_OUT'(lzCnt);
        manNext = normMan;
      end
    end else begin
      expNext = EXP_OUT'(expIn) + BIAS_ADJ;
      manNext = manIn;
    end
  end

  assign wordNext = {sgn, expNext, manNext, {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN)            outWord <= '0;
    else if (strobe.load) outWord <= wordNext;
  end

  AST_SIGN_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outWord[OUT_W-1] == $past(inWord[IN_W-1])); // R1
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outWord[PAD_W-1:0] == '0); // R3
  AST_INF_NAN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && expIn == '1) |=>
      (outWord[OUT_W-2 -: EXP_OUT] == '1 &&
       outWord[MAN_OUT-1 -: MAN_IN] == $past(manIn))); // R4
  AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && expIn == '0 && manIn == '0) |=>
      outWord[OUT_W-2:0] == '0); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(outWord)); // R8
endmodule

// File: rtl/half_to_single.sv
module half_to_single
  import h2s_pkg::*;
#(
  parameter int EXP_IN  = 5,
  parameter int MAN_IN  = 10,
  parameter int EXP_OUT = 8,
  parameter int MAN_OUT = 23
)(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic [EXP_IN+MAN_IN:0]         inHalf,
  output logic                           outValid,
  output logic [EXP_OUT+MAN_OUT:0]       outSingle
);
  ctrlStrobeT strobe;

  h2s_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  h2s_datapath #(
    .EXP_IN  (EXP_IN),
    .MAN_IN  (MAN_IN),
    .EXP_OUT (EXP_OUT),
    .MAN_OUT (MAN_OUT)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inWord  (inHalf),
    .outWord (outSingle)
  );
endmodule

// File: tb/sim_half_to_single.sv
module sim_half_to_single;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inHalf = '0;
  logic        outValid;
  logic [31:0] outSingle;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  half_to_single u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inHalf(inHalf),
    .outValid(outValid), .outSingle(outSingle)
  );

  function automatic logic [31:0] refConv(input logic [15:0] h);
    logic [4:0]  e;
    logic [10:0] m;
    int          ex;
    e = h[14:10];
    m = {1'b0, h[9:0]};
    if (e == 5'd31) return {h[15], 8'hFF, h[9:0], 13'd0};
    if (e == 5'd0) begin
      if (m == 0) return {h[15], 31'd0};
      ex = -14;
      while (m[10] == 1'b0) begin
        m = m << 1;
        ex = ex - 1;
      end
      return {h[15], 8'(ex + 127), m[9:0], 13'd0};
    end
    return {h[15], 8'(int'(e) - 15 + 127), h[9:0], 13'd0};
  endfunction

  function automatic string reqOf(input logic [15:0] h);
    if (h[14:10] == 5'd31) return "R4/R3/R1";
    if (h[14:10] == 5'd0) return (h[9:0] == 0) ? "R6/R1" : "R5/R1";
    return "R2/R3/R1";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [15:0] h);
    @(negedge clk);
    inHalf = h;
    inValid = 1'b1;
    @(negedge clk);
    check(reqOf(h), outSingle, refConv(h));
    check("R7 valid", {31'd0, outValid}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset word", outSingle, 32'd0);
    check("R7 reset valid", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    // directed corners
    runOne(16'h0000); // R6
    runOne(16'h8000); // R6
    runOne(16'h0001); // R5 smallest subnormal
    runOne(16'h03FF); // R5 largest subnormal
    runOne(16'h7C00); // R4 infinity
    runOne(16'hFC00); // R4 negative infinity
    runOne(16'h7E01); // R4 NaN payload
    runOne(16'h3C00); // R2 one
    runOne(16'h7BFF); // R2 max normal
    // full sweep
    for (int i = 0; i < 65536; i++) runOne(16'(i));
    // random with idle cycles
    void'($urandom(32'd4242));
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] h;
      h = 16'($urandom);
      runOne(h);
      if ($urandom % 3 == 0) begin
        @(negedge clk);
        inValid = 1'b0;
        inHalf = ~h;
        @(negedge clk);
        check("R8 hold", outSingle, refConv(h));
        check("R7 idle valid", {31'd0, outValid}, 32'd0);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule